// File: doc/BRIEF.md
# Multichannel Polyphase Distributed-Arithmetic Decimator

This block is a decimate-by-20 FIR stage that serves eight time-interleaved sample streams with one shared set of hardware. Each input word arrives with a stream number. A per-stream phase counter sends it to one of twenty polyphase arms. Each arm keeps, for every stream, a short history of the samples that fall on its phase.

After the twentieth sample of a stream is accepted, every arm copies that stream's history into a parallel-to-serial staging register. The arm then walks the samples one bit per cycle, least significant bit first. On each bit it reads a 16-entry table of coefficient sums. A shift-right accumulator builds the arm's partial product sum from the table values, and the table value is subtracted on the sign-bit slice. The twenty partial sums are added to give one full-precision decimated output, which leaves tagged with its stream number.

The coefficients come from a formula evaluated at elaboration. The sample width is a parameter that may be 16, 24 or 32 bits.

Top module: `decim_poly_da`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after reset, out_valid is 0 and in_ready is 1. Reset clears all histories and phase counters, so samples older than the reset count as zero.
- R2: The prototype coefficients are h[k] = ((37·k + 11) mod 97) − 48 for k = 0..79. Arm p (0..19) holds taps h[p + 20·j] for j = 0..3.
- R3: Number each stream's accepted samples n = 0, 1, 2, .... Every accepted sample with n mod 20 = 19 produces exactly one output for that stream. The output value is y[n] = Σ h[k]·x[n−k] over k = 0..79, sign-extended to the output width, and out_id carries the stream number.
- R4: Streams are independent. Any interleaving of input ids yields, for each stream, the same output sequence as feeding that stream alone.
- R5: Samples are two's complement and the sum is exact. Runs of the most negative and the most positive sample value produce results without wraparound.
- R6: out_valid is high for exactly one cycle per output.
- R7: in_ready goes low in the cycle after a stream's twentieth sample is accepted and stays low for DATA_W+1 cycles. No sample is accepted while it is low.
- R8: out_valid is high in the cycle that follows the clock edge DATA_W+2 edges after the edge that accepted the twentieth sample.
- R9: A reset asserted partway through a run discards the partial histories. Outputs after it equal those of a fresh start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_id | input | 3 | Stream number of the offered sample |
| in_data | input | DATA_W (16) | Two's-complement sample |
| out_valid | output | 1 | One-cycle output strobe |
| out_id | output | 3 | Stream number of the output |
| out_data | output | OUT_W (42) | Full-precision decimated sum |

## Verification
The hardest situation to reach from the ports is a history slot that holds the most negative sample value in every tap while the sign-bit slice subtracts it. Only a long run of full-scale samples on one stream fills all 80 positions of that stream's history. The stimulus therefore drives 80 consecutive most-negative words on one stream, then a run of most-positive words. Every decimated output is compared with a direct 80-tap convolution. A mid-run reset with partly filled histories on two streams confirms that stale state does not leak into later results.

// File: rtl/decim_pkg.sv
package decim_pkg;
   // prototype impulse response, evaluated at elaboration
   function automatic int tap_coef(input int k);
      return ((k * 37 + 11) % 97) - 48;
   endfunction
endpackage

// File: rtl/decim_phase_ctr.sv
module decim_phase_ctr #(
   parameter int NUM_STREAMS = 8,
   parameter int DECIM       = 20,
   localparam int ID_W       = $clog2(NUM_STREAMS),
   localparam int PH_W       = $clog2(DECIM)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            take,
   input  logic [ID_W-1:0] sid,
   output logic [PH_W-1:0] phase,
   output logic            wrap
);
   logic [PH_W-1:0] ph_q [NUM_STREAMS];

   assign phase = ph_q[sid];
   assign wrap  = (phase == PH_W'(DECIM - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_STREAMS; s++) ph_q[s] <= '0;
      end else if (take) begin
         ph_q[sid] <= wrap ? '0 : phase + 1'b1;
      end
   end

   // R3
   phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (take && wrap) |=> (ph_q[$past(sid)] == '0));

   // R3
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      take |=> (ph_q[$past(sid)] < PH_W'(DECIM)));
endmodule

// File: rtl/decim_da_arm.sv
module decim_da_arm #(
   parameter int NUM_STREAMS = 8,
   parameter int DECIM       = 20,
   parameter int TAPS        = 4,
   parameter int DATA_W      = 16,
   parameter int LUT_W       = 19,
   parameter int ARM_W       = 37,
   parameter int ARM_IDX     = 0,
   localparam int ID_W       = $clog2(NUM_STREAMS),
   localparam int LUT_N      = 2 ** TAPS
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [ID_W-1:0]         wr_sid,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    load,
   input  logic [ID_W-1:0]         load_sid,
   input  logic                    step,
   input  logic                    last_bit,
   output logic signed [ARM_W-1:0] acc
);
   // sum of this arm's coefficients selected by the address bits
   function automatic int lut_sum(input int a);
      int s;
      s = 0;
      for (int j = 0; j < TAPS; j++)
         if (a[j]) s += decim_pkg::tap_coef(ARM_IDX + DECIM * j);
      return s;
   endfunction

   logic [DATA_W-1:0]       hist_q [NUM_STREAMS][TAPS];
   logic [DATA_W-1:0]       shf_q  [TAPS];
   logic signed [LUT_W-1:0] lut    [LUT_N];
   logic [TAPS-1:0]         addr;
   logic signed [LUT_W-1:0] term;
   logic signed [ARM_W-1:0] term_ext;
   logic signed [ARM_W-1:0] acc_q;

   for (genvar a = 0; a < LUT_N; a++) begin : g_lut
      assign lut[a] = LUT_W'(lut_sum(a));
   end

   for (genvar j = 0; j < TAPS; j++) begin : g_addr
      assign addr[j] = shf_q[j][0];
   end

   assign term     = last_bit ? -lut[addr] : lut[addr];
   assign term_ext = ARM_W'(term) <<< DATA_W;
   assign acc      = acc_q;

   // per-stream tap line for this phase, newest in slot 0
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_STREAMS; s++)
            for (int j = 0; j < TAPS; j++) hist_q[s][j] <= '0;
      end else if (wr_en) begin
         hist_q[wr_sid][0] <= wr_data;
         for (int j = 1; j < TAPS; j++) hist_q[wr_sid][j] <= hist_q[wr_sid][j-1];
      end
   end

   // parallel-to-serial staging and shift-right accumulation
   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         for (int j = 0; j < TAPS; j++) shf_q[j] <= '0;
      end else if (load) begin
         acc_q <= '0;
         for (int j = 0; j < TAPS; j++) shf_q[j] <= hist_q[load_sid][j];
      end else if (step) begin
         acc_q <= (acc_q + term_ext) >>> 1;
         for (int j = 0; j < TAPS; j++) shf_q[j] <= shf_q[j] >> 1;
      end
   end
endmodule

// File: rtl/decim_poly_da.sv
module decim_poly_da #(
   parameter int NUM_STREAMS = 8,
   parameter int DECIM       = 20,
   parameter int TAPS        = 4,
   parameter int DATA_W      = 16,
   parameter int COEF_W      = 16,
   localparam int ID_W       = $clog2(NUM_STREAMS),
   localparam int PH_W       = $clog2(DECIM),
   localparam int BIT_W      = $clog2(DATA_W),
   localparam int LUT_W      = COEF_W + $clog2(TAPS) + 1,
   localparam int ARM_W      = DATA_W + LUT_W + 2,
   localparam int OUT_W      = ARM_W + $clog2(DECIM)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [ID_W-1:0]         in_id,
   input  logic [DATA_W-1:0]       in_data,
   output logic                    out_valid,
   output logic [ID_W-1:0]         out_id,
   output logic signed [OUT_W-1:0] out_data
);
   if (!(DATA_W == 16 || DATA_W == 24 || DATA_W == 32)) begin : g_bad_width
      $error("sample width must be 16, 24 or 32");
   end
   if ((1 << ID_W) != NUM_STREAMS) begin : g_bad_streams
      $error("stream count must be a power of two");
   end
   if (TAPS < 1 || TAPS > 6 || DECIM < 2 || COEF_W < 8) begin : g_bad_shape
      $error("unsupported arm shape");
   end

   logic                    take, wrap;
   logic [PH_W-1:0]         phase;
   logic                    pend_q, busy_q, fin_q, last_bit;
   logic [BIT_W-1:0]        bit_q;
   logic [ID_W-1:0]         pend_sid_q, work_sid_q;
   logic signed [ARM_W-1:0] arm_acc [DECIM];
   logic signed [OUT_W-1:0] arm_total;

   assign in_ready = !pend_q && !busy_q;
   assign take     = in_valid && in_ready;
   assign last_bit = (bit_q == BIT_W'(DATA_W - 1));

   decim_phase_ctr #(.NUM_STREAMS(NUM_STREAMS), .DECIM(DECIM)) i_phase (
      .clk(clk), .rst(rst), .take(take), .sid(in_id), .phase(phase), .wrap(wrap));

   for (genvar p = 0; p < DECIM; p++) begin : g_arm
      logic wr_en;
      assign wr_en = take && (phase == PH_W'(DECIM - 1 - p));
      decim_da_arm #(
         .NUM_STREAMS(NUM_STREAMS), .DECIM(DECIM), .TAPS(TAPS), .DATA_W(DATA_W),
         .LUT_W(LUT_W), .ARM_W(ARM_W), .ARM_IDX(p)
      ) i_arm (
         .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sid(in_id), .wr_data(in_data),
         .load(pend_q), .load_sid(pend_sid_q), .step(busy_q), .last_bit(last_bit),
         .acc(arm_acc[p]));
   end

   always_comb begin
      arm_total = '0;
      for (int p = 0; p < DECIM; p++) arm_total = arm_total + OUT_W'(arm_acc[p]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q     <= 1'b0;
         busy_q     <= 1'b0;
         fin_q      <= 1'b0;
         bit_q      <= '0;
         pend_sid_q <= '0;
         work_sid_q <= '0;
         out_valid  <= 1'b0;
         out_id     <= '0;
         out_data   <= '0;
      end else begin
         pend_q <= take && wrap;
         if (take && wrap) pend_sid_q <= in_id;
         if (pend_q) begin
            busy_q     <= 1'b1;
            bit_q      <= '0;
            work_sid_q <= pend_sid_q;
         end else if (busy_q) begin
            bit_q <= bit_q + 1'b1;
            if (last_bit) busy_q <= 1'b0;
         end
         fin_q     <= busy_q && last_bit;
         out_valid <= fin_q;
         if (fin_q) begin
            out_id   <= work_sid_q;
            out_data <= arm_total;
         end
      end
   end

   // R1
   rst_state_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready));

   // R6
   pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R7
   stall_chk: assert property (@(posedge clk) disable iff (rst)
      (take && wrap) |=> !in_ready);

   // R8
   bit_cnt_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !last_bit) |=> (busy_q && bit_q == $past(bit_q) + 1'b1));

   // R8
   fin_out_chk: assert property (@(posedge clk) disable iff (rst)
      fin_q |=> (out_valid && out_id == $past(work_sid_q)));
endmodule

// File: tb/test_decim_poly_da.sv
module test_decim_poly_da;
   localparam int NS    = 8;
   localparam int DEC   = 20;
   localparam int NT    = 4;
   localparam int DW    = 16;
   localparam int CW    = 16;
   localparam int NTAP  = DEC * NT;
   localparam int LUT_W = CW + $clog2(NT) + 1;
   localparam int ARM_W = DW + LUT_W + 2;
   localparam int OUT_W = ARM_W + $clog2(DEC);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [2:0] in_id = '0;
   logic [DW-1:0] in_data = '0;
   logic out_valid;
   logic [2:0] out_id;
   logic signed [OUT_W-1:0] out_data;

   always #2 clk = ~clk;

   decim_poly_da i_decim_poly_da (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_id(in_id), .in_data(in_data), .out_valid(out_valid),
      .out_id(out_id), .out_data(out_data));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   longint hist_x [NS][2048];
   int     n_cnt  [NS];
   longint exp_q  [NS][$];

   function automatic longint coef(int k);
      return longint'(((k * 37 + 11) % 97) - 48);
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp, string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int s = 0; s < NS; s++) begin
         n_cnt[s] = 0;
         exp_q[s].delete();
      end
   endtask

   task automatic model_push(int sid, logic [DW-1:0] d);
      int n;
      longint y;
      n = n_cnt[sid];
      hist_x[sid][n] = longint'($signed(d));
      n_cnt[sid] = n + 1;
      if (n % DEC == DEC - 1) begin
         y = 0;
         for (int k = 0; k < NTAP; k++)
            if (n - k >= 0) y += coef(k) * hist_x[sid][n-k];
         exp_q[sid].push_back(y);
      end
   endtask

   task automatic send(int sid, logic [DW-1:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_id    = 3'(sid);
      in_data  = d;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
      model_push(sid, d);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      model_clear();
      rst = 1'b0;
   endtask

   task automatic drain(string req);
      repeat (DW + 10) @(negedge clk);
      for (int s = 0; s < NS; s++)
         check(exp_q[s].size() == 0, req, exp_q[s].size(), 0, "outputs still missing");
   endtask

   // output monitor: value and id against the convolution model
   bit prev_ov = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         prev_ov <= 1'b0;
      end else begin
         if (out_valid) begin
            // R6: single-cycle strobe
            check(!prev_ov, "R6", 1, 0, "out_valid held");
            if (exp_q[out_id].size() == 0) begin
               check(1'b0, cur_req, out_id, -1, "unexpected output on stream");
            end else begin
               longint e;
               e = exp_q[out_id].pop_front();
               check(longint'(out_data) == e, cur_req, longint'(out_data), e, "output value");
            end
         end
         prev_ov <= out_valid;
      end
   end

   task automatic t_reset_state();
      cur_req = "R1";
      @(negedge clk);
      check(out_valid == 1'b0, "R1", out_valid, 0, "out_valid after reset");
      check(in_ready == 1'b1, "R1", in_ready, 1, "in_ready after reset");
   endtask

   task automatic t_single_stream();
      cur_req = "R2";
      for (int i = 0; i < 60; i++) send(0, DW'($urandom));
      // R3: exactly one output per 20 samples, all delivered
      drain("R3");
   endtask

   task automatic t_interleaved();
      cur_req = "R4";
      for (int r = 0; r < 40; r++)
         for (int s = 0; s < NS; s++) send((s * 5 + r) % NS, DW'($urandom));
      drain("R4");
   endtask

   task automatic t_extremes();
      cur_req = "R5";
      for (int i = 0; i < 80; i++) send(3, {1'b1, {(DW-1){1'b0}}});
      for (int i = 0; i < 40; i++) send(3, {1'b0, {(DW-1){1'b1}}});
      drain("R5");
   endtask

   task automatic t_timing();
      int low_cnt;
      int ov_at;
      cur_req = "R8";
      for (int i = 0; i < DEC - 1; i++) send(5, DW'($urandom));
      send(5, DW'($urandom));
      low_cnt = 0;
      ov_at = -1;
      for (int k = 1; k <= DW + 4; k++) begin
         @(negedge clk);
         if (!in_ready && low_cnt == k - 1) low_cnt++;
         if (out_valid && ov_at < 0) ov_at = k;
      end
      // R7: stall length after the twentieth sample
      check(low_cnt == DW + 1, "R7", low_cnt, DW + 1, "in_ready low cycles");
      // R8: output latency
      check(ov_at == DW + 3, "R8", ov_at, DW + 3, "out_valid cycle after accept");
      drain("R8");
   endtask

   task automatic t_mid_reset();
      cur_req = "R9";
      for (int i = 0; i < 10; i++) send(1, DW'($urandom));
      for (int i = 0; i < 33; i++) send(6, DW'($urandom));
      do_reset();
      @(negedge clk);
      check(in_ready == 1'b1, "R9", in_ready, 1, "in_ready after mid-run reset");
      for (int i = 0; i < 40; i++) begin
         send(1, DW'($urandom));
         send(6, DW'($urandom));
      end
      drain("R9");
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      model_clear();
      do_reset();
      t_reset_state();
      t_single_stream();
      t_interleaved();
      t_extremes();
      t_timing();
      t_mid_reset();
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      summary();
   end
endmodule